// File: doc/BRIEF.md
# Ethernet Transmit Frame Builder

This block turns a host byte stream into a complete Ethernet packet on a byte-wide output. The host supplies the frame body as a stream of bytes: destination address, source address, length/type and LLC data. Both the host side and the transmit side use valid/ready handshakes.

Around that body the builder adds a fixed preamble and a start-of-frame delimiter. It pads a short body with zero bytes up to the minimum frame size. It then appends a 4-byte CRC-32 frame check sequence. Three per-frame controls change this behaviour: one suppresses padding so that short packets can be sent, one suppresses the check sequence, and one accepts bodies above the normal maximum length.

An oversize body is never cut short. It is sent in full, and an error flag is raised on its final beat unless long-packet mode was selected. After each packet the output stays idle for a programmable gap, and that gap is never shorter than 12 byte times.

Top module: `eth_tx_framer`

## Requirements
- R1: Every packet starts with seven bytes of 0x55 followed by one byte of 0xD5, before any host byte.
- R2: Host bytes appear on `m_data` unchanged and in order, directly after 0xD5. Bit 0 of each `m_data` byte is the first bit on the wire.
- R3: With `cfg_no_pad` low, a frame body shorter than 60 bytes (header plus fewer than 46 LLC bytes) is followed by 0x00 bytes until the body reaches 60 bytes. A body of 60 bytes or more gets no pad bytes.
- R4: With `cfg_no_pad` high, no pad byte is sent, whatever the body length.
- R5: With `cfg_no_fcs` low, four check bytes follow the body and any pad bytes. They carry the CRC-32 (polynomial 0x04C11DB7, preset all ones, result complemented) of the body and pad bytes, in reflected bit order, lowest byte first. For the body "123456789" they are 0x26, 0x39, 0xF4, 0xCB.
- R6: With `cfg_no_fcs` high, no check bytes are sent, and `m_last` marks the final body or pad byte.
- R7: A body longer than 1514 bytes (more than 1500 LLC bytes) is sent in full. With `cfg_long_ok` low, `m_err` is high on its final beat. With `cfg_long_ok` high, or for a body of 1514 bytes or fewer, `m_err` stays low.
- R8: `s_ready` is low while the preamble, delimiter, pad bytes, check bytes and idle gap are sent. During the body it follows `m_ready`.
- R9: After the last beat of a packet, `m_valid` stays low for G+1 cycles when the next frame is already waiting. G is the larger of `cfg_gap` and 12.
- R10: `m_last` is high only on the final beat of a packet, and `m_err` is high only together with `m_last`. Once `m_valid` is high without `m_ready`, `m_valid` and `m_data` hold until the beat is accepted.
- R11: While `rst_n` is low, `m_valid`, `s_ready` and `m_last` are low.
- R12: The control inputs are sampled when a frame starts. Changing them while that frame is being sent has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_no_pad | input | 1 | Suppress padding for the next frame |
| cfg_no_fcs | input | 1 | Suppress the check sequence for the next frame |
| cfg_long_ok | input | 1 | Accept bodies above 1514 bytes without error |
| cfg_gap | input | 8 | Requested idle gap in byte times (minimum 12 applied) |
| s_valid | input | 1 | Host byte valid |
| s_data | input | 8 | Host byte |
| s_last | input | 1 | Host byte is the last byte of the frame body |
| s_ready | output | 1 | Builder accepts the host byte |
| m_valid | output | 1 | Transmit byte valid |
| m_data | output | 8 | Transmit byte, bit 0 sent first |
| m_last | output | 1 | Final byte of the packet |
| m_err | output | 1 | Oversize frame, valid with m_last |
| m_ready | input | 1 | Transmit side accepts the byte |

## Verification
The assertions assume the host obeys the handshake. Once it raises `s_valid`, it keeps `s_valid`, `s_data` and `s_last` steady until the byte is taken. It ends every frame with `s_last`. The hold-while-stalled property depends on this, because during the body the output valid is the host valid. The bench host drops `s_valid` only between accepted bytes, never while a byte waits. It stalls the output side with a fixed ready pattern, and it changes the control inputs only between frames, except in the one case written to test that a mid-frame change is ignored.

// File: rtl/eth_tx_framer.sv
module eth_tx_framer #(
  parameter int          PRE_LEN = 7,
  parameter int          MIN_LEN = 60,
  parameter int          MAX_LEN = 1514,
  parameter int          MIN_GAP = 12,
  parameter int          GAP_W   = 8,
  parameter int          CNT_W   = 16,
  parameter logic [31:0] POLY    = 32'h04C11DB7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_no_pad,
  input  logic             cfg_no_fcs,
  input  logic             cfg_long_ok,
  input  logic [GAP_W-1:0] cfg_gap,
  input  logic             s_valid,
  input  logic [7:0]       s_data,
  input  logic             s_last,
  output logic             s_ready,
  output logic             m_valid,
  output logic [7:0]       m_data,
  output logic             m_last,
  output logic             m_err,
  input  logic             m_ready
);

  function automatic logic [31:0] rev32(input logic [31:0] v);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = v[31-i];
    return r;
  endfunction

  localparam logic [31:0] POLY_R = rev32(POLY);
  localparam int SUB_W = (PRE_LEN > 4) ? $clog2(PRE_LEN) : 2;
  localparam logic [SUB_W-1:0] PRE_END = SUB_W'(PRE_LEN - 1);
  localparam logic [CNT_W-1:0] MIN_C = CNT_W'(MIN_LEN);
  localparam logic [CNT_W-1:0] MAX_C = CNT_W'(MAX_LEN);
  localparam logic [GAP_W-1:0] GAP_MIN = GAP_W'(MIN_GAP);

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] x;
    x = c;
    for (int i = 0; i < 8; i++)
      x = {1'b0, x[31:1]} ^ ((x[0] ^ d[i]) ? POLY_R : 32'h0);
    return x;
  endfunction

  typedef enum logic [2:0] {S_IDLE, S_PRE, S_SFD, S_DATA, S_PAD, S_FCS, S_GAP} state_t;

  state_t           state;
  logic [SUB_W-1:0] sub;
  logic [CNT_W-1:0] cnt;
  logic [31:0]      crc;
  logic [GAP_W-1:0] gap_cnt, gap_len;
  logic             f_nopad, f_nofcs, f_long, ovf;

  logic [CNT_W-1:0] cnt_nx;
  logic [31:0]      fcs;
  logic             data_fire, need_pad, big, pad_end;

  assign cnt_nx    = (&cnt) ? cnt : cnt + 1'b1;
  assign fcs       = ~crc;
  assign data_fire = (state == S_DATA) && s_valid && m_ready;
  assign need_pad  = !f_nopad && (cnt_nx < MIN_C);
  assign pad_end   = (cnt_nx == MIN_C);
  assign big       = data_fire && !f_long && (cnt >= MAX_C);
  assign s_ready   = (state == S_DATA) && m_ready;

  always_comb begin
    m_valid = 1'b0;
    m_data  = 8'h00;
    m_last  = 1'b0;
    unique case (state)
      S_PRE:  begin m_valid = 1'b1; m_data = 8'h55; end
      S_SFD:  begin m_valid = 1'b1; m_data = 8'hD5; end
      S_DATA: begin
        m_valid = s_valid;
        m_data  = s_data;
        m_last  = s_valid && s_last && !need_pad && f_nofcs;
      end
      S_PAD:  begin m_valid = 1'b1; m_last = pad_end && f_nofcs; end
      S_FCS:  begin
        m_valid = 1'b1;
        m_last  = (sub[1:0] == 2'd3);
        unique case (sub[1:0])
          2'd0: m_data = fcs[7:0];
          2'd1: m_data = fcs[15:8];
          2'd2: m_data = fcs[23:16];
          default: m_data = fcs[31:24];
        endcase
      end
      default: ;
    endcase
  end

  assign m_err = m_last && (ovf || big);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      sub     <= '0;
      cnt     <= '0;
      crc     <= '1;
      gap_cnt <= '0;
      gap_len <= GAP_MIN;
      f_nopad <= 1'b0;
      f_nofcs <= 1'b0;
      f_long  <= 1'b0;
      ovf     <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE: if (s_valid) begin
          f_nopad <= cfg_no_pad;
          f_nofcs <= cfg_no_fcs;
          f_long  <= cfg_long_ok;
          gap_len <= (cfg_gap < GAP_MIN) ? GAP_MIN : cfg_gap;
          sub     <= '0;
          state   <= S_PRE;
        end
        S_PRE: if (m_ready) begin
          if (sub == PRE_END) state <= S_SFD;
          else sub <= sub + 1'b1;
        end
        S_SFD: if (m_ready) begin
          cnt   <= '0;
          crc   <= '1;
          ovf   <= 1'b0;
          state <= S_DATA;
        end
        S_DATA: if (data_fire) begin
          crc <= crc_step(crc, s_data);
          cnt <= cnt_nx;
          if (big) ovf <= 1'b1;
          if (s_last) begin
            sub     <= '0;
            gap_cnt <= '0;
            if (need_pad)     state <= S_PAD;
            else if (f_nofcs) state <= S_GAP;
            else              state <= S_FCS;
          end
        end
        S_PAD: if (m_ready) begin
          crc <= crc_step(crc, 8'h00);
          cnt <= cnt_nx;
          if (pad_end) state <= f_nofcs ? S_GAP : S_FCS;
        end
        S_FCS: if (m_ready) begin
          if (sub[1:0] == 2'd3) state <= S_GAP;
          sub <= sub + 1'b1;
        end
        S_GAP: begin
          gap_cnt <= gap_cnt + 1'b1;
          if (gap_cnt == gap_len - 1'b1) state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

module eth_tx_framer_chk #(
  parameter int MIN_GAP = 12
) (
  input logic       clk,
  input logic       rst_n,
  input logic       s_ready,
  input logic       m_valid,
  input logic [7:0] m_data,
  input logic       m_last,
  input logic       m_err,
  input logic       m_ready
);
  logic       in_pkt;
  logic [7:0] since;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_pkt <= 1'b0;
      since  <= 8'hFF;
    end else if (m_valid && m_ready) begin
      in_pkt <= !m_last;
      if (m_last) since <= '0;
    end else if (since != 8'hFF) begin
      since <= since + 1'b1;
    end
  end

  p_first_pre_r1: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !in_pkt |-> m_data == 8'h55);

  p_ready_path_r8: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> m_ready);

  p_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !in_pkt |-> since >= 8'(MIN_GAP));

  p_err_last_r10: assert property (@(posedge clk) disable iff (!rst_n)
    m_err |-> m_last && m_valid);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable(m_data));
endmodule

bind eth_tx_framer eth_tx_framer_chk #(.MIN_GAP(MIN_GAP)) u_chk (
  .clk(clk), .rst_n(rst_n), .s_ready(s_ready), .m_valid(m_valid),
  .m_data(m_data), .m_last(m_last), .m_err(m_err), .m_ready(m_ready)
);

// File: tb/test_eth_tx_framer.sv
module test_eth_tx_framer;
  localparam int CLK_PERIOD = 10;
  localparam int NCASE = 11;
  localparam logic [31:0] GEN = 32'h04C11DB7;

  localparam int C_LEN  [NCASE] = '{14, 59, 60, 61, 20, 40, 25, 1514, 1515, 1600, 30};
  localparam int C_NOPAD[NCASE] = '{ 0,  0,  0,  0,  1,  0,  1,    0,    0,    0,  0};
  localparam int C_NOFCS[NCASE] = '{ 0,  0,  0,  0,  0,  1,  1,    0,    0,    0,  0};
  localparam int C_LONG [NCASE] = '{ 0,  0,  0,  0,  0,  0,  0,    0,    0,    1,  0};
  localparam int C_GAP  [NCASE] = '{12, 20,  5, 12, 12, 12, 30,   12,   12,   12, 12};
  localparam int C_MODE [NCASE] = '{ 0,  1,  0,  2,  0,  1,  2,    0,    1,    0,  0};
  localparam int C_FLIP [NCASE] = '{ 0,  0,  0,  0,  0,  0,  0,    0,    0,    0,  1};

  logic clk = 0, rst_n = 0;
  logic cfg_no_pad = 0, cfg_no_fcs = 0, cfg_long_ok = 0;
  logic [7:0] cfg_gap = 8'd12;
  logic s_valid = 0, s_last = 0, m_ready = 0;
  logic [7:0] s_data = 0;
  logic s_ready, m_valid, m_last, m_err;
  logic [7:0] m_data;

  eth_tx_framer i_eth_tx_framer (
    .clk(clk), .rst_n(rst_n), .cfg_no_pad(cfg_no_pad), .cfg_no_fcs(cfg_no_fcs),
    .cfg_long_ok(cfg_long_ok), .cfg_gap(cfg_gap), .s_valid(s_valid), .s_data(s_data),
    .s_last(s_last), .s_ready(s_ready), .m_valid(m_valid), .m_data(m_data),
    .m_last(m_last), .m_err(m_err), .m_ready(m_ready)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_bad = 0;
  logic [7:0] tx[$], exp_q[$], got[$];
  bit rdy_q[$];
  int gap_cnt_tb = 0, gap_seen = 0, prev_gap = 0;
  bit armed = 0, gap_new = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic logic [31:0] ref_fcs(input int n);
    logic [31:0] c, r;
    logic [7:0] b;
    c = 32'hFFFFFFFF;
    for (int k = 0; k < n; k++) begin
      for (int j = 0; j < 8; j++) b[j] = exp_q[8+k][7-j];
      c = c ^ {b, 24'h0};
      for (int j = 0; j < 8; j++) c = c[31] ? ((c << 1) ^ GEN) : (c << 1);
    end
    for (int j = 0; j < 32; j++) r[j] = c[31-j];
    return ~r;
  endfunction

  always @(negedge clk) begin
    #2;
    if (m_valid && m_ready && m_last) begin
      armed = 1; gap_cnt_tb = 0;
    end else if (armed && !m_valid) gap_cnt_tb++;
    else if (armed && m_valid) begin
      gap_seen = gap_cnt_tb; armed = 0; gap_new = 1;
    end
  end

  task automatic run_case(input int nopad, nofcs, lng, gap, mode, flip);
    int len, flen, mis, egap;
    bit err_mid, err_last;
    logic [31:0] f;
    string ptag;
    len = tx.size();
    flen = (!nopad && len < 60) ? 60 : len;
    exp_q.delete();
    for (int k = 0; k < 7; k++) exp_q.push_back(8'h55);
    exp_q.push_back(8'hD5);
    for (int k = 0; k < len; k++) exp_q.push_back(tx[k]);
    for (int k = len; k < flen; k++) exp_q.push_back(8'h00);
    if (!nofcs) begin
      f = ref_fcs(flen);
      for (int k = 0; k < 4; k++) exp_q.push_back(f[8*k +: 8]);
    end
    cfg_no_pad = nopad[0]; cfg_no_fcs = nofcs[0]; cfg_long_ok = lng[0]; cfg_gap = gap[7:0];
    got.delete(); rdy_q.delete();
    err_mid = 0; err_last = 0;
    fork
      begin : drv
        int i = 0;
        bit bub = 0;
        while (i < len) begin
          @(negedge clk);
          if (mode == 2 && i % 4 == 3 && !bub) begin
            s_valid = 0; bub = 1;
          end else begin
            s_valid = 1; s_data = tx[i]; s_last = (i == len - 1);
            #1;
            if (s_ready) begin
              i++; bub = 0;
              if (flip != 0 && i == 5) begin
                cfg_no_pad = 1; cfg_no_fcs = 1; cfg_long_ok = 1;
              end
            end
          end
        end
        @(negedge clk);
        s_valid = 0; s_last = 0;
      end
      begin : mon
        int mc = 0;
        bit done = 0;
        while (!done) begin
          @(negedge clk);
          m_ready = (mode == 1) ? (mc % 3 != 0) : 1'b1;
          mc++;
          #1;
          if (m_valid && m_ready) begin
            got.push_back(m_data); rdy_q.push_back(s_ready);
            if (m_err && !m_last) err_mid = 1;
            if (m_last) begin err_last = m_err; done = 1; end
          end
        end
      end
    join
    if (gap_new) begin
      chk(gap_seen == prev_gap + 1, "R9", "idle cycles", gap_seen, prev_gap + 1);
      gap_new = 0;
    end
    egap = (gap < 12) ? 12 : gap;
    prev_gap = egap;
    ptag = nofcs ? "R6" : (nopad ? "R4" : "R3");
    chk(got.size() == exp_q.size(), ptag, "packet length", got.size(), exp_q.size());
    if (got.size() == exp_q.size()) begin
      mis = -1;
      for (int k = 0; k < 8; k++) if (mis < 0 && got[k] != exp_q[k]) mis = k;
      chk(mis < 0, "R1", "preamble byte", mis < 0 ? 0 : got[mis], mis < 0 ? 0 : exp_q[mis]);
      mis = -1;
      for (int k = 8; k < 8 + len; k++) if (mis < 0 && got[k] != exp_q[k]) mis = k;
      chk(mis < 0, "R2", "body byte", mis < 0 ? 0 : got[mis], mis < 0 ? 0 : exp_q[mis]);
      mis = -1;
      for (int k = 8 + len; k < 8 + flen; k++) if (mis < 0 && got[k] != 8'h00) mis = k;
      chk(mis < 0, ptag, "pad byte", mis < 0 ? 0 : got[mis], 0);
      mis = -1;
      for (int k = 8 + flen; k < got.size(); k++) if (mis < 0 && got[k] != exp_q[k]) mis = k;
      chk(mis < 0, "R5", "check byte", mis < 0 ? 0 : got[mis], mis < 0 ? 0 : exp_q[mis]);
      mis = -1;
      for (int k = 0; k < rdy_q.size(); k++)
        if (mis < 0 && rdy_q[k] != (k >= 8 && k < 8 + len)) mis = k;
      chk(mis < 0, "R8", "s_ready at beat", mis, -1);
    end
    chk(err_last == (!lng && len > 1514), "R7", "m_err on last beat", err_last, !lng && len > 1514);
    chk(!err_mid, "R10", "m_err before last beat", err_mid, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    chk(0, "watchdog", "timeout", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 2 + 1);
    s_valid = 1;
    #1;
    chk(!m_valid, "R11", "m_valid in reset", m_valid, 0);
    chk(!s_ready, "R11", "s_ready in reset", s_ready, 0);
    chk(!m_last, "R11", "m_last in reset", m_last, 0);
    s_valid = 0;
    @(negedge clk);
    rst_n = 1;
    for (int c = 0; c < NCASE; c++) begin
      tx.delete();
      for (int k = 0; k < C_LEN[c]; k++) tx.push_back(8'((k * 37 + c * 11 + 3) & 255));
      run_case(C_NOPAD[c], C_NOFCS[c], C_LONG[c], C_GAP[c], C_MODE[c], C_FLIP[c]);
      if (C_FLIP[c] != 0)
        chk(got.size() == 8 + 60 + 4, "R12", "config changed mid-frame", got.size(), 72);
    end
    tx.delete();
    for (int k = 0; k < 9; k++) tx.push_back(8'h31 + 8'(k));
    run_case(1, 0, 0, 12, 0, 0);
    if (got.size() == 21) begin
      chk(got[17] == 8'h26 && got[18] == 8'h39, "R5", "known check low half",
          {got[18], got[17]}, 16'h3926);
      chk(got[19] == 8'hF4 && got[20] == 8'hCB, "R5", "known check high half",
          {got[20], got[19]}, 16'hCBF4);
    end else chk(0, "R5", "known vector length", got.size(), 21);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule